// File: doc/BRIEF.md
# Repeater Preamble Regenerator

This block sits in the data path of a multiport 10 Mb/s repeater. When carrier appears on one of its ports, it selects that port as the source. It retransmits the frame to every other port and copies the same stream onto an expansion output, so that further repeater devices can be cascaded. The incoming preamble, which may be short or damaged, is replaced by a freshly generated one of guaranteed length. The received start-of-frame delimiter is located in the incoming stream. The data bits that follow it are held in a small bit FIFO until the new preamble and delimiter have been sent, and they then drain in order.

A frame that turns out too short on the wire, including a pure preamble fragment with no delimiter, is padded with an alternating jam pattern. The padding brings the repeated burst to exactly the minimum frame length. All bit-level work advances only on a single-cycle bit-time enable. The block therefore runs from any system clock that is faster than the line rate.

Top module: `repeater_regen`

## Requirements
- R1: Each repeated burst starts with an even number of at least 62 preamble bits that alternate 1,0,… starting with 1. These are followed by the delimiter 10101011, sent left bit first.
- R2: When the repeated burst would be shorter than 96 bits, it is extended with jam bits alternating 1,0,… (first jam bit 1) to exactly 96 bits. A burst that already has 96 bits or more gets no jam.
- R3: While `tx_en` is high, `tx_mask` has a 1 for every port except the source port. While `tx_en` is low it is all zeros, and it does not change during a burst.
- R4: `exp_en` and `exp_data` equal `tx_en` and `tx_data` at all times.
- R5: The bits received after the delimiter are repeated in the same order right after the transmitted delimiter, with none lost. This holds even when the received frame has no preamble bits at all.
- R6: When several ports raise carrier in the same bit time, the lowest-numbered port becomes the source. The carrier and data of the other ports have no effect on the burst.
- R7: If carrier ends before a delimiter is seen, the burst is exactly 96 bits and starts with a 1.
- R8: `tx_en` and `tx_data` change only on bit-enable cycles. `tx_en` drops one bit time after the last preamble, data or jam bit, and `tx_data` is 0 from then until the next burst.
- R9: After reset, `tx_en`, `tx_data`, `tx_mask` and the expansion outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per line bit time |
| rx_crs | input | NPORTS | Per-port carrier sense |
| rx_data | input | NPORTS | Per-port received serial bit |
| tx_en | output | 1 | Transmit enable for the repeated burst |
| tx_data | output | 1 | Repeated serial bit |
| tx_mask | output | NPORTS | Ports that take the burst (all but the source) |
| exp_en | output | 1 | Expansion copy of transmit enable |
| exp_data | output | 1 | Expansion copy of the repeated bit |

## Verification
The stimulus includes frames with no received preamble and a long payload. These drive the FIFO to its deepest point, where a buffer that is too small or wraps wrongly corrupts or drops data bits. Preambles longer than the minimum check that the block waits for the received delimiter instead of cutting in early. A delimiter sent at the wrong phase would show up as an odd or broken preamble. Fragments below 96 bits, a frame landing on exactly 96, and a delimiter-less burst expose off-by-one padding and a wrong jam phase. Two ports starting together test the source choice, since a wrong pick shows up as a wrong mask or as foreign data in the output.

// File: rtl/repeater_regen.sv
module repeater_regen #(
  parameter int NPORTS     = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int PRE_MIN    = 62,
  parameter int MIN_FRAME  = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [NPORTS-1:0] rx_crs,
  input  logic [NPORTS-1:0] rx_data,
  output logic              tx_en,
  output logic              tx_data,
  output logic [NPORTS-1:0] tx_mask,
  output logic              exp_en,
  output logic              exp_data
);

  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(MIN_FRAME + PRE_MIN + 1) + 1;
  localparam logic [7:0] DELIM = 8'b1010_1011;
  localparam logic [CW-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_DATA, S_JAM} st_t;

  st_t           st;
  logic [PW-1:0] src, pick;
  logic          rx_on, sfd_seen, alt;
  logic [7:0]    shreg;
  logic [2:0]    sidx;
  logic [CW-1:0] txcnt;
  logic          fifo_mem [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_comb begin
    pick = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (rx_crs[i]) pick = PW'(i);
  end

  wire any_crs  = |rx_crs;
  wire src_bit  = rx_data[src];
  wire [7:0] sh_next = {shreg[6:0], src_bit};
  wire empty    = (cnt == '0);
  wire full     = (cnt == (AW+1)'(FIFO_DEPTH));
  wire push     = bit_en && (st != S_IDLE) && rx_on && rx_crs[src] && sfd_seen;
  wire pop      = bit_en && (st == S_DATA) && !empty;
  wire go_sfd   = sfd_seen && (txcnt >= CW'(PRE_MIN)) && alt;
  wire fin      = ((st == S_PRE) && !rx_on && !sfd_seen) ||
                  ((st == S_DATA) && empty && !rx_on);
  wire short_tx = (txcnt < CW'(MIN_FRAME));
  wire [CW-1:0] txcnt_inc = (txcnt == CNT_MAX) ? txcnt : txcnt + 1'b1;

  // receive side: source lock, delimiter hunt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src      <= '0;
      rx_on    <= 1'b0;
      sfd_seen <= 1'b0;
      shreg    <= '0;
    end else if (bit_en) begin
      if (st == S_IDLE) begin
        if (any_crs) begin
          src      <= pick;
          rx_on    <= 1'b1;
          sfd_seen <= 1'b0;
          shreg    <= {7'b0, rx_data[pick]};
        end else begin
          rx_on <= 1'b0;
        end
      end else if (rx_on) begin
        if (!rx_crs[src]) begin
          rx_on <= 1'b0;
        end else if (!sfd_seen) begin
          shreg <= sh_next;
          if (sh_next == DELIM) sfd_seen <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) fifo_mem[wp] <= src_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop)           rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push && !full) - (AW+1)'(pop);
    end
  end

  // transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tx_en   <= 1'b0;
      tx_data <= 1'b0;
      txcnt   <= '0;
      alt     <= 1'b0;
      sidx    <= '0;
    end else if (bit_en) begin
      if (fin) begin
        if (short_tx) begin
          st      <= S_JAM;
          tx_data <= 1'b1;
          alt     <= 1'b0;
          txcnt   <= txcnt_inc;
        end else begin
          st      <= S_IDLE;
          tx_en   <= 1'b0;
          tx_data <= 1'b0;
        end
      end else begin
        case (st)
          S_IDLE: if (any_crs) begin
            st      <= S_PRE;
            tx_en   <= 1'b1;
            tx_data <= 1'b1;
            txcnt   <= CW'(1);
            alt     <= 1'b0;
          end
          S_PRE: begin
            txcnt <= txcnt_inc;
            if (go_sfd) begin
              st      <= S_SFD;
              tx_data <= 1'b1;
              sidx    <= 3'd1;
            end else begin
              tx_data <= alt;
              alt     <= ~alt;
            end
          end
          S_SFD: begin
            txcnt   <= txcnt_inc;
            tx_data <= (sidx == 3'd7) | ~sidx[0];
            sidx    <= sidx + 1'b1;
            if (sidx == 3'd7) st <= S_DATA;
          end
          S_DATA: begin
            if (!empty) begin
              tx_data <= fifo_mem[rp];
              txcnt   <= txcnt_inc;
            end else begin
              tx_data <= 1'b0;
            end
          end
          S_JAM: begin
            if (short_tx) begin
              tx_data <= alt;
              alt     <= ~alt;
              txcnt   <= txcnt_inc;
            end else begin
              st      <= S_IDLE;
              tx_en   <= 1'b0;
              tx_data <= 1'b0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign tx_mask  = tx_en ? ~(NPORTS'(1) << src) : '0;
  assign exp_en   = tx_en;
  assign exp_data = tx_data;

  assert_delim_late_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SFD && $past(st) == S_PRE) |-> txcnt > CW'(PRE_MIN));

  assert_min_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> txcnt >= CW'(MIN_FRAME));

  assert_mask_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !$rose(tx_en)) |-> $stable(tx_mask));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st == S_DATA && rx_on) |-> !empty);

  assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_en) && $stable(tx_data)));

endmodule

// File: tb/repeater_regen_tb.sv
module repeater_regen_tb;
  localparam int NP = 4;
  localparam int PRE_MIN = 62;
  localparam int MIN_FRAME = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [NP-1:0] rx_crs = '0;
  logic [NP-1:0] rx_data = '0;
  logic tx_en, tx_data, exp_en, exp_data;
  logic [NP-1:0] tx_mask;

  always #4 clk = ~clk;

  repeater_regen #(.NPORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_crs(rx_crs), .rx_data(rx_data),
    .tx_en(tx_en), .tx_data(tx_data), .tx_mask(tx_mask),
    .exp_en(exp_en), .exp_data(exp_data));

  typedef struct {int port; int dlen; bit sfd; int extra;} frame_t;
  frame_t desc_q[$];
  bit     exp_bits[$];
  bit     burst[$];
  int     n_chk = 0, n_bad = 0;
  bit     done = 0, in_burst = 0;
  int     mask_bad, exp_bad;
  frame_t cur;
  logic   ben_seen = 1'b0;

  always @(posedge clk) ben_seen <= bit_en;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic analyze();
    frame_t f;
    int n, s, pre, bad, et, base;
    bit ok, e;
    f = desc_q.pop_front();
    n = burst.size();
    chk(mask_bad == 0, (f.extra >= 0) ? "R6 mask" : "R3 mask", mask_bad, 0);
    chk(exp_bad == 0, "R4 expansion", exp_bad, 0);
    if (f.sfd) begin
      s = -1;
      for (int k = 1; k < n; k++) if (s < 0 && burst[k] && burst[k-1]) s = k;
      pre = s - 7;
      ok = (s >= 7) && (pre >= PRE_MIN) && (pre % 2 == 0);
      if (ok) begin
        for (int k = 0; k < pre; k++) if (burst[k] != (k % 2 == 0)) ok = 0;
        for (int k = 0; k < 8; k++) if (burst[pre+k] != (k == 7 || k % 2 == 0)) ok = 0;
      end
      chk(ok, "R1 preamble", pre, PRE_MIN);
      if (s < 0) s = n;
      bad = 0;
      for (int k = 0; k < f.dlen; k++) begin
        e = exp_bits.pop_front();
        if (s + 1 + k >= n || burst[s+1+k] != e) bad++;
      end
      chk(bad == 0, (f.extra >= 0) ? "R6 data" : "R5 data", bad, 0);
      base = s + 1 + f.dlen;
      et = (base < MIN_FRAME) ? MIN_FRAME : base;
      chk(n == et, "R2 length", n, et);
      bad = 0;
      for (int k = base; k < n; k++) if (burst[k] != ((k - base) % 2 == 0)) bad++;
      chk(bad == 0, "R2 jam", bad, 0);
    end else begin
      chk(n == MIN_FRAME, "R7 length", n, MIN_FRAME);
      chk(n > 0 && burst[0] == 1'b1, "R7 first", (n > 0) ? int'(burst[0]) : -1, 1);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (ben_seen) begin
      if (tx_en) begin
        if (!in_burst) begin
          in_burst = 1;
          burst.delete();
          mask_bad = 0;
          exp_bad = 0;
          if (desc_q.size() == 0) begin
            chk(0, "R8 spurious burst", 1, 0);
            cur.port = 0; cur.dlen = 0; cur.sfd = 0; cur.extra = -1;
          end else cur = desc_q[0];
        end
        burst.push_back(tx_data);
        if (tx_mask != (~(NP'(1) << cur.port))) mask_bad++;
        if (exp_en !== tx_en || exp_data !== tx_data) exp_bad++;
      end else if (in_burst) begin
        in_burst = 0;
        chk(tx_data == 1'b0 && tx_mask == '0, "R8 idle after burst",
            int'({tx_data, tx_mask}), 0);
        if (desc_q.size() != 0) analyze();
      end
    end
  end

  task automatic bit_step(input logic [NP-1:0] c, input logic [NP-1:0] d);
    @(negedge clk);
    rx_crs = c; rx_data = d; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] mk(input int port, input bit b, input int extra);
    logic [NP-1:0] v;
    v = '0;
    v[port] = b;
    if (extra >= 0) v[extra] = ~b;
    return v;
  endfunction

  task automatic send_frame(input int port, input int pre, input int dlen,
                            input bit sfd, input int extra);
    frame_t f;
    logic [NP-1:0] c;
    bit b;
    f.port = port; f.dlen = dlen; f.sfd = sfd; f.extra = extra;
    desc_q.push_back(f);
    c = NP'(1) << port;
    if (extra >= 0) c[extra] = 1'b1;
    for (int i = 0; i < pre; i++) bit_step(c, mk(port, (i % 2 == 0), extra));
    if (sfd) for (int i = 0; i < 8; i++) bit_step(c, mk(port, (i == 7 || i % 2 == 0), extra));
    for (int i = 0; i < dlen; i++) begin
      b = 1'($urandom_range(0, 1));
      exp_bits.push_back(b);
      bit_step(c, mk(port, b, extra));
    end
    repeat (100) bit_step('0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_en == 0 && tx_data == 0, "R9 tx reset", int'({tx_en, tx_data}), 0);
    chk(tx_mask == '0, "R9 mask reset", int'(tx_mask), 0);
    chk(exp_en == 0 && exp_data == 0, "R9 expansion reset", int'({exp_en, exp_data}), 0);
    rst_n = 1'b1;
    repeat (10) bit_step('0, '0);
    send_frame(0, 56, 64, 1, -1);   // R1 R5 typical frame
    send_frame(2, 8, 100, 1, -1);   // R5 short preamble, deep FIFO
    send_frame(1, 80, 40, 1, -1);   // R1 long preamble waits for delimiter
    send_frame(3, 20, 4, 1, -1);    // R2 fragment padded
    send_frame(0, 30, 0, 0, -1);    // R7 no delimiter
    send_frame(3, 0, 120, 1, -1);   // R5 no preamble at all
    send_frame(2, 10, 26, 1, -1);   // R2 exactly 96, no jam
    send_frame(1, 56, 32, 1, 2);    // R6 simultaneous carrier
    chk(desc_q.size() == 0, "R8 all frames repeated", desc_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule